// File: doc/BRIEF.md
# Fixed Off-Time Mixed-Decay Current Chopper

This block regulates the winding current of one full-bridge phase of a stepper driver. Each clock edge is one master-oscillator cycle. It starts an on-phase by closing a diagonal pair of switches. It waits for the external current-sense comparator to trip, then runs a fixed-length off-time and returns to the on state. Between any switch turning off and its complementary switch on the same leg turning on, it inserts a dead time. Before it listens to the comparator again, it applies a blanking window.

The step sequencer tells the block whether the current magnitude is rising or falling. While the current rises, the whole off-time uses slow decay: the winding recirculates through both low-side switches. While it falls, the block uses mixed decay. It drives the reverse diagonal (fast decay) for a programmable share of the off-time, then moves to slow decay for the rest. A disable input masks all four gate enables and leaves the internal timing running.

Top module: `chop_ctrl`

## Requirements
- R1: With the latched polarity at 1 the on-phase drives `hs_a` and `ls_b`; with it at 0 it drives `hs_b` and `ls_a`. The polarity is taken from `dir` when reset is released and again on the last dead-time cycle before each on-phase. It is held constant otherwise.
- R2: While `rst_n` is low (sampled at a clock edge), all four gate enables are 0. On the first clock edge with `rst_n` high, the on-phase begins.
- R3: A high `cmp_trip` sampled in the on state ends the on-phase at that edge. The off-time that follows lasts exactly OFF_CYC = 87 cycles.
- R4: In slow decay (current rising, or fraction code 0), only the source switch opens. For the first DEAD_CYC = 3 off cycles only the sink low-side is on. For the rest of the off-time both low-side switches are on.
- R5: In mixed decay (`i_falling` high at the trip), the fast share F is set by `fast_sel`: code 0 gives 0, 1 gives 13, 2 gives 41 and 3 gives 87 cycles. The sequence is: 3 cycles all off, then the reverse diagonal until F off cycles have passed, then 3 cycles with only the source-leg low-side on, then both low-sides. With F = 87 the whole off-time is fast.
- R6: After the off-time, all switches are off for 3 cycles before the on diagonal closes. No enable rises while the other enable of the same leg was on in the previous cycle.
- R7: After that dead time, the diagonal is on for BLANK_CYC = 6 cycles with `cmp_trip` ignored. A trip on the first cycle after blanking ends the on-phase at once, so the on state lasts one cycle.
- R8: While `out_dis` is high, all four enables are 0. The sequence timing continues unchanged.
- R9: The high-side and low-side enables of the same leg are never both 1.
- R10: `i_falling` and `fast_sel` are sampled only at the trip edge. Changes during the off-time do not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master oscillator clock, one cycle per tick |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_trip | input | 1 | Current-sense comparator output, high when current reached its limit |
| dir | input | 1 | Desired current polarity through the winding |
| i_falling | input | 1 | High when the commanded current magnitude is decreasing |
| fast_sel | input | 2 | Fast-decay share code for mixed decay |
| out_dis | input | 1 | Forces all gate enables off when high |
| hs_a | output | 1 | High-side enable, leg A |
| ls_a | output | 1 | Low-side enable, leg A |
| hs_b | output | 1 | High-side enable, leg B |
| ls_b | output | 1 | Low-side enable, leg B |

## Verification
A comparator held high on every cycle checks the repeat period and confirms that trips during blanking are ignored. It also checks that a trip on the first free cycle acts at once. Single trip pulses with the falling flag set, sweeping each fraction code under both polarities, separate the four fast/slow splits and the special cases of no fast share and a fully fast off-time. Random stimulus changes direction, fraction, falling flag and disable in the middle of a sequence. Each cycle is compared with a timeline model, which shows whether sampling and latching happen at the right edges.

// File: rtl/chop_pkg.sv
package chop_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ON,
      ST_DEAD_OFF,
      ST_OFF_FAST,
      ST_DEAD_MID,
      ST_OFF_SLOW,
      ST_DEAD_ON,
      ST_BLANK
   } chop_state_e;

   typedef struct packed {
      logic hs_a;
      logic ls_a;
      logic hs_b;
      logic ls_b;
   } gate_t;

endpackage

// File: rtl/chop_frac_lut.sv
module chop_frac_lut #(
   parameter int          OFF_CYC  = 87,
   parameter int          DEAD_CYC = 3,
   parameter int          CW       = 7,
   parameter logic [31:0] FAST_PCT = 32'h64_30_0F_00
) (
   input  logic [1:0]    sel,
   output logic [CW-1:0] fast_n
);

   localparam int N_CODES = 4;

   logic [CW-1:0] tbl [N_CODES];

   for (genvar g = 0; g < N_CODES; g++) begin : g_code
      localparam int PCT = int'(FAST_PCT[g*8 +: 8]);
      localparam int CYC = (OFF_CYC * PCT) / 100;
      if (PCT > 100) begin : g_bad_pct
         $error("fast share above 100 percent");
      end
      if (CYC != 0 && CYC != OFF_CYC &&
          (CYC <= DEAD_CYC || CYC >= OFF_CYC - DEAD_CYC)) begin : g_bad_split
         $error("fast share leaves no room for a dead time");
      end
      assign tbl[g] = CW'(CYC);
   end

   assign fast_n = tbl[sel];

endmodule

// File: rtl/chop_seq.sv
module chop_seq
   import chop_pkg::*;
#(
   parameter int OFF_CYC   = 87,
   parameter int DEAD_CYC  = 3,
   parameter int BLANK_CYC = 6,
   parameter int CW        = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          trip,
   input  logic          dir,
   input  logic          falling,
   input  logic [CW-1:0] fast_n,
   output chop_state_e   state,
   output logic          pol,
   output logic          fast_mode
);

   localparam logic [CW-1:0] C_DEAD   = CW'(DEAD_CYC - 1);
   localparam logic [CW-1:0] C_BLANK  = CW'(BLANK_CYC - 1);
   localparam logic [CW-1:0] C_OFF    = CW'(OFF_CYC);
   localparam logic [CW-1:0] C_SLOW   = CW'(OFF_CYC - DEAD_CYC - 1);
   localparam logic [CW-1:0] C_FADJ   = CW'(DEAD_CYC + 1);

   if (DEAD_CYC < 1 || BLANK_CYC < 1) begin : g_bad_len
      $error("dead and blanking lengths must be at least one cycle");
   end
   if (OFF_CYC <= 2 * DEAD_CYC + 1) begin : g_bad_off
      $error("off-time too short for two dead times");
   end

   logic [CW-1:0] cnt;
   logic [CW-1:0] fast_len;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         cnt       <= '0;
         pol       <= 1'b0;
         fast_mode <= 1'b0;
         fast_len  <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               state <= ST_ON;
               pol   <= dir;
            end
            ST_ON: begin
               if (trip) begin
                  state     <= ST_DEAD_OFF;
                  cnt       <= C_DEAD;
                  fast_mode <= falling && (fast_n != '0);
                  fast_len  <= fast_n;
               end
            end
            ST_DEAD_OFF: begin
               if (cnt == '0) begin
                  if (fast_mode) begin
                     state <= ST_OFF_FAST;
                     cnt   <= fast_len - C_FADJ;
                  end else begin
                     state <= ST_OFF_SLOW;
                     cnt   <= C_SLOW;
                  end
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            ST_OFF_FAST: begin
               if (cnt == '0) begin
                  state <= (fast_len == C_OFF) ? ST_DEAD_ON : ST_DEAD_MID;
                  cnt   <= C_DEAD;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            ST_DEAD_MID: begin
               if (cnt == '0) begin
                  state <= ST_OFF_SLOW;
                  cnt   <= C_SLOW - fast_len;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            ST_OFF_SLOW: begin
               if (cnt == '0) begin
                  state <= ST_DEAD_ON;
                  cnt   <= C_DEAD;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            ST_DEAD_ON: begin
               if (cnt == '0) begin
                  state <= ST_BLANK;
                  cnt   <= C_BLANK;
                  pol   <= dir;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            ST_BLANK: begin
               if (cnt == '0) state <= ST_ON;
               else           cnt   <= cnt - 1'b1;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   AST_IDLE_LEAVES: assert property (@(posedge clk) disable iff (!rst_n)
      state == ST_IDLE |=> state == ST_ON); // R2
   AST_TRIP_ENDS_ON: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_ON && trip) |=> state == ST_DEAD_OFF); // R3
   AST_BLANK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_BLANK && cnt != '0) |=> state == ST_BLANK); // R7
   AST_POL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_DEAD_ON && state != ST_IDLE) |=> $stable(pol)); // R1
   AST_SPLIT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_ON) |=> $stable(fast_len)); // R10

endmodule

// File: rtl/chop_gates.sv
module chop_gates
   import chop_pkg::*;
(
   input  chop_state_e state,
   input  logic        pol,
   input  logic        fast_mode,
   input  logic        dis,
   output gate_t       gates
);

   logic src_hi, src_lo, snk_hi, snk_lo;

   always_comb begin
      src_hi = 1'b0;
      src_lo = 1'b0;
      snk_hi = 1'b0;
      snk_lo = 1'b0;
      case (state)
         ST_ON, ST_BLANK: begin
            src_hi = 1'b1;
            snk_lo = 1'b1;
         end
         ST_DEAD_OFF: snk_lo = !fast_mode;
         ST_OFF_FAST: begin
            snk_hi = 1'b1;
            src_lo = 1'b1;
         end
         ST_DEAD_MID: src_lo = 1'b1;
         ST_OFF_SLOW: begin
            src_lo = 1'b1;
            snk_lo = 1'b1;
         end
         default: ;
      endcase
   end

   always_comb begin
      if (dis) begin
         gates = '0;
      end else if (pol) begin
         gates = '{hs_a: src_hi, ls_a: src_lo, hs_b: snk_hi, ls_b: snk_lo};
      end else begin
         gates = '{hs_a: snk_hi, ls_a: snk_lo, hs_b: src_hi, ls_b: src_lo};
      end
   end

endmodule

// File: rtl/chop_ctrl.sv
module chop_ctrl
   import chop_pkg::*;
#(
   parameter int          OFF_CYC   = 87,
   parameter int          DEAD_CYC  = 3,
   parameter int          BLANK_CYC = 6,
   parameter logic [31:0] FAST_PCT  = 32'h64_30_0F_00
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmp_trip,
   input  logic       dir,
   input  logic       i_falling,
   input  logic [1:0] fast_sel,
   input  logic       out_dis,
   output logic       hs_a,
   output logic       ls_a,
   output logic       hs_b,
   output logic       ls_b
);

   localparam int CW = $clog2(OFF_CYC + 1);

   if (BLANK_CYC > OFF_CYC || DEAD_CYC > OFF_CYC) begin : g_bad_cw
      $error("blank and dead lengths must not exceed the off-time");
   end

   logic [CW-1:0] fast_n;
   chop_state_e   state;
   logic          pol;
   logic          fast_mode;
   gate_t         gates;

   chop_frac_lut #(
      .OFF_CYC (OFF_CYC),
      .DEAD_CYC(DEAD_CYC),
      .CW      (CW),
      .FAST_PCT(FAST_PCT)
   ) u_lut (
      .sel   (fast_sel),
      .fast_n(fast_n)
   );

   chop_seq #(
      .OFF_CYC  (OFF_CYC),
      .DEAD_CYC (DEAD_CYC),
      .BLANK_CYC(BLANK_CYC),
      .CW       (CW)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .trip     (cmp_trip),
      .dir      (dir),
      .falling  (i_falling),
      .fast_n   (fast_n),
      .state    (state),
      .pol      (pol),
      .fast_mode(fast_mode)
   );

   chop_gates u_gates (
      .state    (state),
      .pol      (pol),
      .fast_mode(fast_mode),
      .dis      (out_dis),
      .gates    (gates)
   );

   assign hs_a = gates.hs_a;
   assign ls_a = gates.ls_a;
   assign hs_b = gates.hs_b;
   assign ls_b = gates.ls_b;

   AST_LEG_A_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(hs_a && ls_a)); // R9
   AST_LEG_B_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(hs_b && ls_b)); // R9
   AST_DEAD_HS_A: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hs_a) |-> !$past(ls_a)); // R6
   AST_DEAD_LS_A: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ls_a) |-> !$past(hs_a)); // R6
   AST_DEAD_HS_B: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hs_b) |-> !$past(ls_b)); // R6
   AST_DEAD_LS_B: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ls_b) |-> !$past(hs_b)); // R6

endmodule

// File: tb/chop_ctrl_tb.sv
module chop_ctrl_tb;

   localparam int OFF = 87;
   localparam int DT  = 3;
   localparam int BL  = 6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmp_trip = 1'b0;
   logic       dir = 1'b1;
   logic       i_falling = 1'b0;
   logic [1:0] fast_sel = 2'd0;
   logic       out_dis = 1'b0;
   logic       hs_a, ls_a, hs_b, ls_b;

   int n_checks = 0;
   int n_errs   = 0;
   bit done     = 1'b0;

   chop_ctrl u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmp_trip (cmp_trip),
      .dir      (dir),
      .i_falling(i_falling),
      .fast_sel (fast_sel),
      .out_dis  (out_dis),
      .hs_a     (hs_a),
      .ls_a     (ls_a),
      .hs_b     (hs_b),
      .ls_b     (ls_b)
   );

   always #10 clk = ~clk;

   // timeline model: m_t counts cycles since the trip edge
   bit m_idle = 1'b1;
   bit m_on   = 1'b0;
   bit m_seq  = 1'b0;
   bit m_pol  = 1'b0;
   bit m_fast = 1'b0;
   int m_f    = 0;
   int m_t    = 0;

   function automatic int frac_cyc(input logic [1:0] s);
      case (s)
         2'd0:    return 0;
         2'd1:    return (OFF * 15) / 100;
         2'd2:    return (OFF * 48) / 100;
         default: return OFF;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_idle = 1'b1; m_on = 1'b0; m_seq = 1'b0; m_pol = 1'b0;
      end else if (m_idle) begin
         m_idle = 1'b0; m_on = 1'b1; m_pol = dir;
      end else if (m_on) begin
         if (cmp_trip) begin
            m_on = 1'b0; m_seq = 1'b1; m_t = 0;
            m_f = frac_cyc(fast_sel);
            m_fast = i_falling && (m_f != 0);
         end
      end else if (m_seq) begin
         if (m_t == OFF + DT - 1) m_pol = dir;
         if (m_t == OFF + DT + BL - 1) begin
            m_seq = 1'b0; m_on = 1'b1;
         end else begin
            m_t++;
         end
      end
   end

   // {src_hi, src_lo, snk_hi, snk_lo}
   function automatic logic [3:0] frame_bits();
      if (m_idle) return 4'b0000;
      if (m_on) return 4'b1001;
      if (m_t < DT) return m_fast ? 4'b0000 : 4'b0001;
      if (m_fast && m_t < m_f) return 4'b0110;
      if (m_fast && m_f < OFF && m_t < m_f + DT) return 4'b0100;
      if (m_t < OFF) return 4'b0101;
      if (m_t < OFF + DT) return 4'b0000;
      return 4'b1001;
   endfunction

   function automatic logic [3:0] exp_gates();
      logic [3:0] f;
      if (out_dis) return 4'b0000;
      f = frame_bits();
      return m_pol ? f : {f[1:0], f[3:2]};
   endfunction

   function automatic string req_tag();
      if (m_idle) return "R2";
      if (out_dis) return "R8";
      if (m_on) return "R1";
      if (m_t < OFF) return m_fast ? "R5" : "R4";
      if (m_t < OFF + DT) return "R6";
      return "R7";
   endfunction

   task automatic chk(input string tag, input logic [3:0] got, input logic [3:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_errs++;
         $display("FAIL %s t=%0t gates(hs_a,ls_a,hs_b,ls_b) got=%b exp=%b",
                  tag, $time, got, exp);
      end
   endtask

   task automatic cyc(input bit trip, input bit d, input bit fall,
                      input logic [1:0] sel, input bit dis);
      @(negedge clk);
      chk(req_tag(), {hs_a, ls_a, hs_b, ls_b}, exp_gates());
      if ((hs_a && ls_a) || (hs_b && ls_b))
         chk("R9", 4'b1111, 4'b0000);
      cmp_trip = trip; dir = d; i_falling = fall; fast_sel = sel; out_dis = dis;
   endtask

   task automatic pulse_run(input bit d, input logic [1:0] sel, input bit fall);
      for (int i = 0; i < 5; i++) cyc(1'b0, d, fall, sel, 1'b0);
      cyc(1'b1, d, fall, sel, 1'b0);
      // R10: flip fraction and falling during the off-time
      for (int i = 0; i < 110; i++) cyc(1'b0, d, !fall, ~sel, 1'b0);
   endtask

   initial begin
      int dummy;
      int hs_rises;
      bit prev_hs;
      dummy = $urandom(32'h5EED_0042);
      // R2: reset held
      for (int i = 0; i < 4; i++) cyc(1'b0, 1'b1, 1'b0, 2'd0, 1'b0);
      @(negedge clk);
      chk("R2", {hs_a, ls_a, hs_b, ls_b}, 4'b0000);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R2", {hs_a, ls_a, hs_b, ls_b}, 4'b1001);
      // R7/R3: comparator stuck high; period 1+OFF+DT+BL
      hs_rises = 0; prev_hs = hs_a;
      for (int i = 0; i < 3 * (1 + OFF + DT + BL); i++) begin
         cyc(1'b1, 1'b1, 1'b0, 2'd0, 1'b0);
         if (hs_a && !prev_hs) hs_rises++;
         prev_hs = hs_a;
      end
      chk("R7", 4'(hs_rises), 4'd3);
      // R5/R10: each fraction code, both polarities
      for (int p = 0; p < 2; p++)
         for (int s = 0; s < 4; s++) pulse_run(p[0], s[1:0], 1'b1);
      // R4: rising current
      pulse_run(1'b1, 2'd3, 1'b0);
      // R8: disable inside a sequence
      cyc(1'b1, 1'b0, 1'b1, 2'd2, 1'b0);
      for (int i = 0; i < 60; i++) cyc(1'b0, 1'b0, 1'b1, 2'd2, 1'b1);
      for (int i = 0; i < 60; i++) cyc(1'b0, 1'b0, 1'b1, 2'd2, 1'b0);
      // random mix
      for (int i = 0; i < 20000; i++) begin
         bit tr, dd, ff, ds;
         tr = ($urandom % 6) == 0;
         dd = ($urandom % 40) == 0 ? !dir : dir;
         ff = ($urandom % 2) == 1;
         ds = ($urandom % 25) == 0 ? !out_dis : out_dis;
         cyc(tr, dd, ff, 2'($urandom % 4), ds);
      end
      // R2: reset mid-run
      cyc(1'b0, 1'b1, 1'b0, 2'd0, 1'b0);
      rst_n = 1'b0;
      for (int i = 0; i < 3; i++) cyc(1'b0, 1'b1, 1'b0, 2'd0, 1'b0);
      rst_n = 1'b1;
      for (int i = 0; i < 3; i++) cyc(1'b0, 1'b0, 1'b0, 2'd0, 1'b0);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
   end

   initial begin
      #(200000 * 20);
      if (!done) begin
         n_checks++;
         n_errs++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
         $finish;
      end
   end

endmodule